// File: doc/BRIEF.md
# Multi-Mode Integer Multiply-Accumulate Unit

This block is a 32-bit integer multiplier with an opcode that picks one of six operations. The opcodes cover a low-word product, a product plus a 32-bit addend, a full 64-bit product in unsigned or two's-complement form, and a 64-bit accumulate. In the accumulate forms, a value presented as a high/low word pair is added to the full product. All six modes share one datapath. The operand sign extension is chosen per opcode, and the addend is selected per opcode.

The unit is pipelined with a fixed latency. A start strobe with its operands is accepted on any cycle. Two clock edges later, a done strobe is raised together with the low and high result words. A new operation may start every cycle.

Top module: `mac_unit`

## Requirements
- R1: Opcode 0 gives res_lo_o equal to the low 32 bits of a_i × b_i.
- R2: Opcode 1 gives res_lo_o equal to the low 32 bits of a_i × b_i + add_i.
- R3: Opcode 2 gives {res_hi_o, res_lo_o} equal to the unsigned 64-bit product of a_i and b_i.
- R4: Opcode 3 gives {res_hi_o, res_lo_o} equal to the two's-complement 64-bit product. This includes the case where either operand, or both, is 0x80000000.
- R5: Opcode 4 gives the unsigned product plus {acc_hi_i, acc_lo_i}, modulo 2^64, with no indication of carry-out.
- R6: Opcode 5 gives the signed product plus the signed value {acc_hi_i, acc_lo_i}, modulo 2^64.
- R7: For opcodes 0 and 1, res_hi_o is zero, and acc_hi_i and acc_lo_i have no effect on the result.
- R8: Opcodes 6 and 7 still raise done_o, and both result words are zero.
- R9: done_o is high in exactly the cycle two clock edges after each cycle with start_i high, and is low otherwise. Back-to-back starts give back-to-back results, each matching its own operands.
- R10: While rst_ni is low, done_o, res_lo_o and res_hi_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation valid strobe |
| op_i | input | 3 | Opcode (0..7) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| add_i | input | 32 | Addend for opcode 1 |
| acc_hi_i | input | 32 | Accumulator high word |
| acc_lo_i | input | 32 | Accumulator low word |
| done_o | output | 1 | Result valid strobe |
| res_lo_o | output | 32 | Result low word |
| res_hi_o | output | 32 | Result high word |

## Verification
Because the unit is pipelined, a new operation enters the multiply stage in the same cycle as an older one is being accumulated and selected. An opcode and its operands can therefore be in flight next to an operation of a different mode. The bench provokes this with back-to-back starts that walk every opcode over a set of corner operands (zero, one, both extremes, all ones, 0x80000000) and accumulators that wrap. Idle gaps are inserted between the bursts. Each done cycle is compared with a 64-bit arithmetic model of the operands issued two cycles earlier. This exposes any leak of opcode, sign or addend from the neighbouring operation.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MLA   = 3'd1,
    OP_UMULL = 3'd2,
    OP_SMULL = 3'd3,
    OP_UMLAL = 3'd4,
    OP_SMLAL = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } mac_op_e;

  function automatic logic op_signed(input mac_op_e op);
    return (op == OP_SMULL) || (op == OP_SMLAL);
  endfunction

  function automatic logic op_short(input mac_op_e op);
    return (op == OP_MUL) || (op == OP_MLA);
  endfunction

  function automatic logic op_valid(input mac_op_e op);
    return (op != OP_RSV6) && (op != OP_RSV7);
  endfunction
endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mac_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   add_i,
  input  logic [W-1:0]   acc_hi_i,
  input  logic [W-1:0]   acc_lo_i,
  output logic [W:0]     a_x_o,
  output logic [W:0]     b_x_o,
  output logic [2*W-1:0] addend_o
);
  logic sgn;

  always_comb begin
    sgn   = op_signed(op_i);
    // one extra bit: sign copy for signed modes, zero otherwise
    a_x_o = {sgn & a_i[W-1], a_i};
    b_x_o = {sgn & b_i[W-1], b_i};
    unique case (op_i)
      OP_MLA:            addend_o = {{W{1'b0}}, add_i};
      OP_UMLAL, OP_SMLAL: addend_o = {acc_hi_i, acc_lo_i};
      default:           addend_o = '0;
    endcase
  end
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  mac_op_e        op_i,
  input  logic [W:0]     a_x_i,
  input  logic [W:0]     b_x_i,
  input  logic [2*W-1:0] addend_i,
  output logic           vld_o,
  output mac_op_e        op_o,
  output logic [2*W-1:0] prod_o,
  output logic [2*W-1:0] addend_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod_d;

  // (W+1)x(W+1) signed product; low 2W bits are exact for both signednesses
  always_comb prod_d = PW'($signed(a_x_i) * $signed(b_x_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      op_o     <= OP_MUL;
      prod_o   <= '0;
      addend_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        op_o     <= op_i;
        prod_o   <= prod_d;
        addend_o <= addend_i;
      end
    end
  end
endmodule

// File: rtl/mac_accum_stage.sv
module mac_accum_stage
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  mac_op_e        op_i,
  input  logic [2*W-1:0] prod_i,
  input  logic [2*W-1:0] addend_i,
  output logic           done_o,
  output logic [W-1:0]   res_lo_o,
  output logic [W-1:0]   res_hi_o
);
  logic [2*W-1:0] sum;
  logic [W-1:0]   lo_d, hi_d;

  always_comb begin
    sum = prod_i + addend_i;  // wraps modulo 2^(2W)
    if (!op_valid(op_i)) begin
      lo_d = '0;
      hi_d = '0;
    end else if (op_short(op_i)) begin
      lo_d = sum[W-1:0];
      hi_d = '0;
    end else begin
      lo_d = sum[W-1:0];
      hi_d = sum[2*W-1:W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      res_lo_o <= '0;
      res_hi_o <= '0;
    end else begin
      done_o <= vld_i;
      if (vld_i) begin
        res_lo_o <= lo_d;
        res_hi_o <= hi_d;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] add_i,
  input  logic [W-1:0] acc_hi_i,
  input  logic [W-1:0] acc_lo_i,
  output logic         done_o,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o
);
  localparam int unsigned PW = 2 * W;

  mac_op_e       op_in, op_s1;
  logic [W:0]    a_x, b_x;
  logic [PW-1:0] addend_s0, addend_s1, prod_s1;
  logic          vld_s1;

  assign op_in = mac_op_e'(op_i);

  mac_operand_prep #(.W(W)) u_prep (
    .op_i    (op_in),
    .a_i     (a_i),
    .b_i     (b_i),
    .add_i   (add_i),
    .acc_hi_i(acc_hi_i),
    .acc_lo_i(acc_lo_i),
    .a_x_o   (a_x),
    .b_x_o   (b_x),
    .addend_o(addend_s0)
  );

  mac_mult_stage #(.W(W)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (start_i),
    .op_i    (op_in),
    .a_x_i   (a_x),
    .b_x_i   (b_x),
    .addend_i(addend_s0),
    .vld_o   (vld_s1),
    .op_o    (op_s1),
    .prod_o  (prod_s1),
    .addend_o(addend_s1)
  );

  mac_accum_stage #(.W(W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (vld_s1),
    .op_i    (op_s1),
    .prod_i  (prod_s1),
    .addend_i(addend_s1),
    .done_o  (done_o),
    .res_lo_o(res_lo_o),
    .res_hi_o(res_hi_o)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         done_o,
  input logic [W-1:0] res_lo_o,
  input logic [W-1:0] res_hi_o
);
  p_done_after_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 done_o);

  p_no_spurious_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ##1 !done_o);

  p_short_hi_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i <= 3'd1) |=> ##1 (res_hi_o == '0));

  p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i >= 3'd6) |=> ##1 (res_lo_o == '0 && res_hi_o == '0));

  p_mul_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd0) |=> ##1 (res_lo_o == W'($past(a_i, 2) * $past(b_i, 2))));

  always @(posedge clk_i)
    if (!rst_ni) a_reset_quiet_r10: assert (!done_o && res_lo_o == '0 && res_hi_o == '0);
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .done_o  (done_o),
  .res_lo_o(res_lo_o),
  .res_hi_o(res_hi_o)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0, add_i = '0, acc_hi_i = '0, acc_lo_i = '0;
  logic         done_o;
  logic [W-1:0] res_lo_o, res_hi_o;

  int n_tests = 0;
  int n_fail  = 0;

  // two-slot model of the pipeline: valid, op, expected 64-bit
  logic        s1_v = 1'b0, s2_v = 1'b0;
  logic [2:0]  s1_op = '0, s2_op = '0;
  logic [63:0] s1_e = '0, s2_e = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mac_unit #(.W(W)) dut (.*);

  function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] ad, input logic [31:0] hi, input logic [31:0] lo);
    logic [63:0] up, sp, acc;
    up  = {32'd0, a} * {32'd0, b};
    sp  = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    acc = {hi, lo};
    case (op)
      3'd0: return {32'd0, up[31:0]};
      3'd1: return {32'd0, 32'(up[31:0] + ad)};
      3'd2: return up;
      3'd3: return sp;
      3'd4: return up + acc;
      3'd5: return sp + acc;
      default: return 64'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R7";
      3'd1: return "R2/R7";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hFFFF_0001;
      default: return 32'h0000_0002;
    endcase
  endfunction

  // called on each falling edge: check outputs, advance model, then drive
  task automatic cycle(input logic st, input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] ad, input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk_i);
    n_tests++;
    if (done_o !== s2_v) begin
      n_fail++;
      $display("FAIL R9 done_o act=%0b exp=%0b", done_o, s2_v);
    end else if (s2_v && {res_hi_o, res_lo_o} !== s2_e) begin
      n_fail++;
      $display("FAIL %s op=%0d act=%h exp=%h", req_of(s2_op), s2_op, {res_hi_o, res_lo_o}, s2_e);
    end
    s2_v = s1_v; s2_op = s1_op; s2_e = s1_e;
    s1_v = st; s1_op = op; s1_e = model(op, a, b, ad, hi, lo);
    start_i = st; op_i = op; a_i = a; b_i = b; add_i = ad; acc_hi_i = hi; acc_lo_i = lo;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    // R10: quiet outputs while held in reset
    repeat (3) @(negedge clk_i);
    n_tests++;
    if (done_o !== 1'b0 || res_lo_o !== '0 || res_hi_o !== '0) begin
      n_fail++;
      $display("FAIL R10 act=%b/%h/%h exp=0/0/0", done_o, res_hi_o, res_lo_o);
    end
    rst_ni = 1'b1;

    // back-to-back sweep: all opcodes over corner operand pairs
    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [31:0] hi, lo;
          hi = corner((i + j + op) % 8);
          lo = corner((i * 3 + j) % 8);
          if (j == 7) begin hi = 32'hFFFF_FFFF; lo = 32'hFFFF_FFFF; end  // wrap past 2^64
          cycle(1'b1, 3'(op), corner(i), corner(j), corner((i + 2 * j) % 8), hi, lo);
        end
        // idle gap of varying length
        for (int g = 0; g < (i % 3); g++) cycle(1'b0, 3'd0, '0, '0, '0, '0, '0);
      end
    end

    // R7: accumulator inputs cannot reach the short-mode result
    for (int k = 0; k < 8; k++) begin
      cycle(1'b1, 3'(k % 2), corner(k), corner(7 - k), corner(k), 32'hDEAD_BEEF, 32'hCAFE_F00D);
    end

    // R4: 0x80000000 on one or both sides, mixed with other modes
    cycle(1'b1, 3'd3, 32'h8000_0000, 32'h8000_0000, '0, '0, '0);
    cycle(1'b1, 3'd3, 32'h8000_0000, 32'hFFFF_FFFF, '0, '0, '0);
    cycle(1'b1, 3'd5, 32'h8000_0000, 32'h0000_0001, '0, 32'h8000_0000, 32'h0);
    cycle(1'b1, 3'd2, 32'h8000_0000, 32'h8000_0000, '0, '0, '0);
    // drain
    repeat (3) cycle(1'b0, 3'd0, '0, '0, '0, '0, '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule